// File: doc/BRIEF.md
# Slow Interleaved Dual-Converter Sequencer

This block runs two sampling converters on one input in a staggered pattern so that together they deliver samples at twice the rate of either one. Once the mode is enabled and a trigger arrives, it pulses the start of the second converter at once. It pulses the first converter half a period later. Both starts then repeat on a fixed period with no further trigger. The converters themselves sit outside the block and are seen only as start pulses going out and done pulses with 12-bit data coming back.

The block keeps the latest result of the second converter. Each time the first converter reports done, it builds one 32-bit word with the second converter's result in the upper halfword and the first converter's result in the lower halfword. Each result is zero-extended to 16 bits. On that same completion it may raise a one-cycle interrupt and a transfer request that is held until it is acknowledged. Each of the two depends on its own enable.

While the mode is on, the block refuses two things. A write that would switch on continuous conversion is dropped. An injected-channel trigger has no effect on the starts and raises a one-cycle error flag.

Top module: `ilv_seq`

## Requirements
- R1: With `mode_en` high and the sequencer idle, a `trig` pulse sampled at a clock edge makes `start_b_o` high for one cycle right after that edge. `start_b_o` then pulses again every 28 cycles, with no further trigger, for as long as `mode_en` stays high.
- R2: `start_a_o` pulses exactly 14 cycles after each `start_b_o` pulse. The two start outputs are never high in the same cycle.
- R3: On a `done_a` pulse with `mode_en` high, `word_o` is updated at the next edge. Bits [31:28] and [15:12] are zero, bits [11:0] hold `data_a`, and bits [27:16] hold the data of the most recent `done_b`. If `done_b` arrives in the same cycle as `done_a`, its `data_b` is the value used.
- R4: `irq_o` is high for exactly one cycle after each `done_a` that is taken while `irq_en` is high, and stays low when `irq_en` is low.
- R5: `req_o` is set after each `done_a` that is taken while `xfer_en` is high, and stays high until a cycle with `ack_i` high. A completion that sets the request wins over an `ack_i` in the same cycle. `req_o` is never set when `xfer_en` is low.
- R6: A `cont_wr` pulse writes `cont_wdata` into the continuous-mode bit seen on `cont_o` only while `mode_en` is low. While `mode_en` is high the write is ignored.
- R7: An `inj_trig` pulse while `mode_en` is high sets `inj_err_o` for one cycle after the edge and does not start either converter. While `mode_en` is low it raises no error.
- R8: Driving `mode_en` low cancels the schedule, so that no start pulse appears from the next cycle on. After `mode_en` goes high again, no start appears until a new `trig`.
- R9: A `trig` pulse while the schedule is already running is ignored, and the 28/14 start pattern continues unchanged.
- R10: After reset, all outputs are low and `word_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Interleaved mode enable |
| irq_en | input | 1 | End-of-conversion interrupt enable |
| xfer_en | input | 1 | Transfer request enable |
| cont_wr | input | 1 | Write strobe for the continuous-mode bit |
| cont_wdata | input | 1 | Value written to the continuous-mode bit |
| trig | input | 1 | Regular conversion trigger |
| inj_trig | input | 1 | Injected-channel trigger (forbidden in this mode) |
| done_a | input | 1 | First converter done pulse |
| data_a | input | 12 | First converter result |
| done_b | input | 1 | Second converter done pulse |
| data_b | input | 12 | Second converter result |
| ack_i | input | 1 | Transfer request acknowledge pulse |
| start_a_o | output | 1 | First converter start pulse |
| start_b_o | output | 1 | Second converter start pulse |
| word_o | output | 32 | Packed result word |
| irq_o | output | 1 | End-of-conversion interrupt pulse |
| req_o | output | 1 | Transfer request, held until acknowledged |
| cont_o | output | 1 | Continuous-mode bit |
| inj_err_o | output | 1 | Injected-trigger error pulse |

## Verification
Every output of the block is registered, so each result is due one edge after its stimulus. This holds for the first `start_b_o` after `trig`, for `word_o`, `irq_o` and `req_o` after `done_a`, for the clearing of `req_o` after `ack_i`, for `inj_err_o` after `inj_trig`, and for `cont_o` after `cont_wr`. Later start pulses are due at fixed offsets of 14 and 28 cycles counted from the first `start_b_o`. The bench applies inputs just after a falling edge and reads outputs at the next falling edge, so each read sees exactly one rising edge. Start outputs are compared on every cycle against the expected position of the cycle within the 28-cycle period.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int unsigned HALF_W = 16;
    localparam int unsigned WORD_W = 2 * HALF_W;

    typedef struct packed {
        logic cont;
        logic err;
    } ctrl_st_t;

endpackage

// File: rtl/ilv_sched.sv
module ilv_sched #(
    parameter int unsigned PERIOD = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic trig,
    output logic start_a_o,
    output logic start_b_o
);

    localparam int unsigned OFFSET = PERIOD / 2;
    localparam int unsigned CW     = $clog2(PERIOD);

    typedef struct packed {
        logic          running;
        logic [CW-1:0] cnt;
        logic          st_a;
        logic          st_b;
    } sched_st_t;

    sched_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!mode_en) begin
            s_d.running = 1'b0;
            s_d.cnt     = '0;
        end else if (!s_q.running) begin
            if (trig) begin
                s_d.running = 1'b1;
                s_d.cnt     = '0;
            end
        end else if (s_q.cnt == CW'(PERIOD - 1)) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        s_d.st_b = s_d.running && (s_d.cnt == '0);
        s_d.st_a = s_d.running && (s_d.cnt == CW'(OFFSET));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start_a_o = s_q.st_a;
    assign start_b_o = s_q.st_b;

endmodule

// File: rtl/ilv_pack.sv
module ilv_pack #(
    parameter int unsigned RES_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mode_en,
    input  logic                        irq_en,
    input  logic                        xfer_en,
    input  logic                        done_a,
    input  logic [RES_W-1:0]            data_a,
    input  logic                        done_b,
    input  logic [RES_W-1:0]            data_b,
    input  logic                        ack_i,
    output logic [ilv_pkg::WORD_W-1:0]  word_o,
    output logic                        irq_o,
    output logic                        req_o
);

    localparam int unsigned PAD = ilv_pkg::HALF_W - RES_W;

    typedef struct packed {
        logic [RES_W-1:0]           res_b;
        logic [ilv_pkg::WORD_W-1:0] word;
        logic                       irq;
        logic                       req;
    } pack_st_t;

    pack_st_t p_d, p_q;
    logic [RES_W-1:0] b_now;

    always_comb begin
        p_d   = p_q;
        p_d.irq = 1'b0;
        b_now = p_q.res_b;
        if (mode_en && done_b) begin
            b_now     = data_b;
            p_d.res_b = data_b;
        end
        if (ack_i) p_d.req = 1'b0;
        if (mode_en && done_a) begin
            p_d.word = {{PAD{1'b0}}, b_now, {PAD{1'b0}}, data_a};
            p_d.irq  = irq_en;
            if (xfer_en) p_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign word_o = p_q.word;
    assign irq_o  = p_q.irq;
    assign req_o  = p_q.req;

endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic cont_wr,
    input  logic cont_wdata,
    input  logic inj_trig,
    output logic cont_o,
    output logic inj_err_o
);

    ilv_pkg::ctrl_st_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.err = mode_en && inj_trig;
        if (cont_wr && !mode_en) c_d.cont = cont_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cont_o    = c_q.cont;
    assign inj_err_o = c_q.err;

endmodule

// File: rtl/ilv_seq.sv
module ilv_seq #(
    parameter int unsigned PERIOD = 28,
    parameter int unsigned RES_W  = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode_en,
    input  logic                       irq_en,
    input  logic                       xfer_en,
    input  logic                       cont_wr,
    input  logic                       cont_wdata,
    input  logic                       trig,
    input  logic                       inj_trig,
    input  logic                       done_a,
    input  logic [RES_W-1:0]           data_a,
    input  logic                       done_b,
    input  logic [RES_W-1:0]           data_b,
    input  logic                       ack_i,
    output logic                       start_a_o,
    output logic                       start_b_o,
    output logic [ilv_pkg::WORD_W-1:0] word_o,
    output logic                       irq_o,
    output logic                       req_o,
    output logic                       cont_o,
    output logic                       inj_err_o
);

    ilv_sched #(.PERIOD(PERIOD)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_en   (mode_en),
        .trig      (trig),
        .start_a_o (start_a_o),
        .start_b_o (start_b_o)
    );

    ilv_pack #(.RES_W(RES_W)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_en (mode_en),
        .irq_en  (irq_en),
        .xfer_en (xfer_en),
        .done_a  (done_a),
        .data_a  (data_a),
        .done_b  (done_b),
        .data_b  (data_b),
        .ack_i   (ack_i),
        .word_o  (word_o),
        .irq_o   (irq_o),
        .req_o   (req_o)
    );

    ilv_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_en    (mode_en),
        .cont_wr    (cont_wr),
        .cont_wdata (cont_wdata),
        .inj_trig   (inj_trig),
        .cont_o     (cont_o),
        .inj_err_o  (inj_err_o)
    );

endmodule

// File: rtl/ilv_seq_chk.sv
module ilv_seq_chk #(
    parameter int unsigned PERIOD = 28,
    parameter int unsigned RES_W  = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       mode_en,
    input logic                       irq_en,
    input logic                       xfer_en,
    input logic                       cont_wr,
    input logic                       inj_trig,
    input logic                       done_a,
    input logic [RES_W-1:0]           data_a,
    input logic                       ack_i,
    input logic                       start_a_o,
    input logic                       start_b_o,
    input logic [ilv_pkg::WORD_W-1:0] word_o,
    input logic                       irq_o,
    input logic                       req_o,
    input logic                       cont_o,
    input logic                       inj_err_o
);

    localparam int unsigned OFFSET = PERIOD / 2;
    localparam int unsigned GW     = $clog2(PERIOD + 2);
    localparam int unsigned PAD    = ilv_pkg::HALF_W - RES_W;

    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (start_b_o)                    gap_q <= GW'(1);
            else if (gap_q != GW'(PERIOD + 1)) gap_q <= gap_q + 1'b1;
            if (!mode_en)       seen_q <= 1'b0;
            else if (start_b_o) seen_q <= 1'b1;
        end
    end

    AST_B_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (start_b_o && seen_q) |-> (gap_q == GW'(PERIOD))); // R1
    AST_A_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        start_a_o |-> (gap_q == GW'(OFFSET))); // R2
    AST_START_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_a_o && start_b_o)); // R2
    AST_WORD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done_a && mode_en) |=> (word_o[ilv_pkg::HALF_W-1:0] == {{PAD{1'b0}}, $past(data_a)})); // R3
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(done_a) && $past(irq_en) && $past(mode_en))); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> req_o); // R5
    AST_REQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> ($past(done_a) && $past(xfer_en))); // R5
    AST_CONT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && cont_wr) |=> $stable(cont_o)); // R6
    AST_INJ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        inj_err_o |-> ($past(inj_trig) && $past(mode_en))); // R7
    AST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> (!start_a_o && !start_b_o)); // R8

endmodule

bind ilv_seq ilv_seq_chk #(.PERIOD(PERIOD), .RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_en   (mode_en),
    .irq_en    (irq_en),
    .xfer_en   (xfer_en),
    .cont_wr   (cont_wr),
    .inj_trig  (inj_trig),
    .done_a    (done_a),
    .data_a    (data_a),
    .ack_i     (ack_i),
    .start_a_o (start_a_o),
    .start_b_o (start_b_o),
    .word_o    (word_o),
    .irq_o     (irq_o),
    .req_o     (req_o),
    .cont_o    (cont_o),
    .inj_err_o (inj_err_o)
);

// File: tb/ilv_seq_bench.sv
`timescale 1ns/1ps
module ilv_seq_bench;

    localparam int PER = 28;
    localparam int OFS = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_en = 0, irq_en = 0, xfer_en = 0, cont_wr = 0, cont_wdata = 0;
    logic trig = 0, inj_trig = 0, done_a = 0, done_b = 0, ack_i = 0;
    logic [11:0] data_a = '0, data_b = '0;
    logic start_a_o, start_b_o, irq_o, req_o, cont_o, inj_err_o;
    logic [31:0] word_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    ilv_seq u_ilv_seq (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .irq_en(irq_en),
        .xfer_en(xfer_en), .cont_wr(cont_wr), .cont_wdata(cont_wdata),
        .trig(trig), .inj_trig(inj_trig), .done_a(done_a), .data_a(data_a),
        .done_b(done_b), .data_b(data_b), .ack_i(ack_i),
        .start_a_o(start_a_o), .start_b_o(start_b_o), .word_o(word_o),
        .irq_o(irq_o), .req_o(req_o), .cont_o(cont_o), .inj_err_o(inj_err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic fire_trig();
        trig = 1'b1;
        cyc();
        trig = 1'b0;
    endtask

    task automatic sched_window(input string tag, input int n, input int trig_at);
        for (int i = 0; i < n; i++) begin
            chk({tag, " R1 start_b"}, 32'(start_b_o), 32'((i % PER) == 0));
            chk({tag, " R2 start_a"}, 32'(start_a_o), 32'((i % PER) == OFS));
            trig = (i == trig_at);
            cyc();
        end
        trig = 1'b0;
    endtask

    task automatic quiet(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            chk({tag, " start_a"}, 32'(start_a_o), 32'd0);
            chk({tag, " start_b"}, 32'(start_b_o), 32'd0);
            cyc();
        end
    endtask

    task automatic t_reset();
        chk("R10 starts", {30'd0, start_a_o, start_b_o}, 32'd0);
        chk("R10 word", word_o, 32'd0);
        chk("R10 flags", {28'd0, irq_o, req_o, cont_o, inj_err_o}, 32'd0);
    endtask

    task automatic t_schedule();
        mode_en = 1'b1;
        cyc();
        fire_trig();
        sched_window("sched", 60, -1);
    endtask

    task automatic t_retrig();
        mode_en = 1'b0;
        cyc();
        mode_en = 1'b1;
        fire_trig();
        sched_window("R9 retrig", 60, 10);
    endtask

    task automatic t_pack();
        irq_en = 1'b1; xfer_en = 1'b1;
        data_b = 12'hABC; done_b = 1'b1;
        cyc();
        done_b = 1'b0; data_a = 12'h123; done_a = 1'b1;
        cyc();
        done_a = 1'b0;
        chk("R3 word", word_o, 32'h0ABC_0123);
        chk("R4 irq set", 32'(irq_o), 32'd1);
        chk("R5 req set", 32'(req_o), 32'd1);
        cyc();
        chk("R4 irq one cycle", 32'(irq_o), 32'd0);
        chk("R5 req held", 32'(req_o), 32'd1);
        ack_i = 1'b1;
        cyc();
        ack_i = 1'b0;
        chk("R5 req acked", 32'(req_o), 32'd0);
        data_b = 12'h5A5; done_b = 1'b1; data_a = 12'hFFF; done_a = 1'b1;
        cyc();
        done_a = 1'b0; done_b = 1'b0;
        chk("R3 same-cycle b", word_o, 32'h05A5_0FFF);
        ack_i = 1'b1; data_a = 12'h001; done_a = 1'b1;
        cyc();
        ack_i = 1'b0; done_a = 1'b0;
        chk("R5 set beats ack", 32'(req_o), 32'd1);
        chk("R3 latched b kept", word_o, 32'h05A5_0001);
        ack_i = 1'b1;
        cyc();
        ack_i = 1'b0;
        irq_en = 1'b0; xfer_en = 1'b0; data_a = 12'h777; done_a = 1'b1;
        cyc();
        done_a = 1'b0;
        chk("R4 irq gated", 32'(irq_o), 32'd0);
        chk("R5 req gated", 32'(req_o), 32'd0);
        chk("R3 word still packed", word_o, 32'h05A5_0777);
    endtask

    task automatic t_cont();
        cont_wr = 1'b1; cont_wdata = 1'b1;
        cyc();
        cont_wr = 1'b0;
        chk("R6 set ignored in mode", 32'(cont_o), 32'd0);
        mode_en = 1'b0; cont_wr = 1'b1;
        cyc();
        cont_wr = 1'b0;
        chk("R6 set accepted off", 32'(cont_o), 32'd1);
        cont_wdata = 1'b0; cont_wr = 1'b1;
        cyc();
        cont_wr = 1'b0;
        chk("R6 clear accepted off", 32'(cont_o), 32'd0);
    endtask

    task automatic t_inj();
        mode_en = 1'b0;
        cyc();
        mode_en = 1'b1; inj_trig = 1'b1;
        cyc();
        inj_trig = 1'b0;
        chk("R7 err pulse", 32'(inj_err_o), 32'd1);
        chk("R7 no start", {30'd0, start_a_o, start_b_o}, 32'd0);
        quiet("R7 ignored", 20);
        chk("R7 err clears", 32'(inj_err_o), 32'd0);
        mode_en = 1'b0; inj_trig = 1'b1;
        cyc();
        inj_trig = 1'b0;
        chk("R7 no err when off", 32'(inj_err_o), 32'd0);
    endtask

    task automatic t_stop();
        mode_en = 1'b1;
        cyc();
        fire_trig();
        sched_window("R8 pre", 20, -1);
        mode_en = 1'b0;
        cyc();
        quiet("R8 stopped", 40);
        mode_en = 1'b1;
        cyc();
        quiet("R8 no restart", 40);
        fire_trig();
        sched_window("R8 restart", 30, -1);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc();
        cyc();
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_schedule();
        t_retrig();
        t_pack();
        t_cont();
        t_inj();
        t_stop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule